// File: doc/BRIEF.md
# Serial Port Data FIFO Path

This block sits between a host data word and a synchronous serial line. The host writes 16-bit words into an eight-entry transmit queue. At each bit strobe the transmit side takes the oldest word, loads it into a shift register and drives it out most significant bit first. The sampled input bits are gathered into a receive shift register. When a frame completes, the received word is pushed into an eight-entry receive queue, which the host drains by reading.

Two settings shape each frame. The word size runs from 4 to 16 bits and is given as size minus one. The command-response flag sends an 8-bit command and then collects a reply of the programmed size. Transmit words are right-justified and their unused upper bits never reach the line. Received words are right-justified with zeros above the data. Dropping the port enable stops new frames from starting but leaves both queues intact, so the host can preload data before it enables the port. Bit strobes come from an external clock generator, one strobe per bit time.

Top module: `ssi_fifo_path`

## Requirements
- R1: After reset both queues are empty, `tx_full` is 0, `rx_empty` is 1, and `busy`, `ser_out` and `rx_overrun` are 0.
- R2: A host write while the transmit queue holds fewer than 8 words appends the word. A write while it holds 8 words is dropped, and `tx_full` is 1 exactly when 8 words are held.
- R3: In normal mode (`cmd_mode`=0) a frame lasts N = `dsize_m1`+1 bit strobes after the loading strobe. `ser_out` presents bit N-1 of the word first, then each lower bit, and word bits N and above are ignored.
- R4: In command-response mode (`cmd_mode`=1) the frame lasts 8+N strobes. `ser_out` sends word bits 7 down to 0 and then 0 for the remaining strobes, and the upper byte of the word is ignored.
- R5: The received word is made of the last N bits sampled on `ser_in` (the earliest of them in bit N-1), and bits N to 15 are zero.
- R6: A read while the receive queue is empty returns 0 on `host_rdata` and changes nothing.
- R7: A frame that completes while the receive queue holds 8 words is discarded, and `rx_overrun` then stays 1 until reset.
- R8: While `en` is 0 no frame starts, and the contents of both queues are kept.
- R9: `busy` is 1 while a frame is shifting or the transmit queue is not empty.
- R10: Both queues deliver words in first-in, first-out order across pointer wrap-around. `host_rdata` always shows the oldest received word, and a read removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable; gates the start of frames |
| dsize_m1 | input | 4 | Word size minus one (3..15) |
| cmd_mode | input | 1 | Command-response mode flag |
| bit_tick | input | 1 | One-cycle bit strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Oldest received word, or 0 when empty |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output |
| tx_full | output | 1 | Transmit queue holds 8 words |
| rx_empty | output | 1 | Receive queue is empty |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| busy | output | 1 | Frame shifting or transmit data pending |

## Verification
The overrun path is the hardest case to reach. It needs eight completed frames with no host read in between, followed by a ninth frame that the transmit queue must still be able to feed. The bench gets there in a directed sequence. It preloads the transmit queue with the port disabled, runs eight frames of mixed sizes and modes, and refills the queue before the overflowing frame. A random phase then mixes reads, writes and frames of random size and mode against a queue model.

// File: rtl/ssi_fifo_path.sv
module ssi_fifo_path #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    dsize_m1,
  input  logic          cmd_mode,
  input  logic          bit_tick,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          tx_full,
  output logic          rx_empty,
  output logic          rx_overrun,
  output logic          busy
);
  localparam int AW  = $clog2(DEPTH);
  localparam int FCW = $clog2(DW + 9);
  localparam logic [3:0] TOP = 4'(DW - 1);

  logic [DW-1:0]  tx_mem [DEPTH];
  logic [DW-1:0]  rx_mem [DEPTH];
  logic [AW-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]    tx_cnt, rx_cnt;
  logic [DW-1:0]  tx_sh, rx_sh;
  logic [FCW-1:0] bits_left;
  logic           active;

  logic          tx_empty;
  logic [4:0]    nbits, tx_nb;
  logic [FCW-1:0] frame_len;
  logic [DW-1:0] dmask, tx_word, rx_word;
  logic          tx_push, tx_pop, step, done, rx_push, rx_pop;

  assign tx_empty  = (tx_cnt == '0);
  assign tx_full   = (tx_cnt == (AW+1)'(DEPTH));
  assign rx_empty  = (rx_cnt == '0);
  assign nbits     = {1'b0, dsize_m1} + 5'd1;
  assign tx_nb     = cmd_mode ? 5'd8 : nbits;
  assign frame_len = cmd_mode ? FCW'(nbits) + FCW'(8) : FCW'(nbits);
  assign dmask     = {DW{1'b1}} >> (TOP - dsize_m1);
  assign tx_word   = tx_mem[tx_rp] & (cmd_mode ? DW'(8'hFF) : dmask);
  assign rx_word   = {rx_sh[DW-2:0], ser_in} & dmask;

  assign tx_push = host_wr && !tx_full;
  assign tx_pop  = bit_tick && en && !active && !tx_empty;
  assign step    = bit_tick && active;
  assign done    = step && (bits_left == FCW'(1));
  assign rx_push = done && !rx_full_w;
  assign rx_pop  = host_rd && !rx_empty;

  logic rx_full_w;
  assign rx_full_w = (rx_cnt == (AW+1)'(DEPTH));

  assign host_rdata = rx_empty ? '0 : rx_mem[rx_rp];
  assign ser_out    = active & tx_sh[DW-1];
  assign busy       = active | !tx_empty;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= host_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_sh <= '0; rx_sh <= '0; bits_left <= '0;
      active <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
      if (tx_pop) begin
        active    <= 1'b1;
        bits_left <= frame_len;
        tx_sh     <= tx_word << (5'(DW) - tx_nb);
        rx_sh     <= '0;
      end else if (step) begin
        tx_sh     <= tx_sh << 1;
        rx_sh     <= {rx_sh[DW-2:0], ser_in};
        bits_left <= bits_left - FCW'(1);
        if (done) active <= 1'b0;
      end
      if (done && rx_full_w) rx_overrun <= 1'b1;
    end
  end

  // R2
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && host_wr && !tx_pop) |=> tx_full);
  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (host_rdata == '0));
  // R6
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && host_rd && !done) |=> rx_empty);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);
  // R8
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !active) |=> !active);
  // R9
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> busy);
  // R3
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ser_out);
endmodule

// File: tb/ssi_fifo_path_tb_top.sv
`timescale 1ns/1ps
module ssi_fifo_path_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, cmd_mode, bit_tick, host_wr, host_rd, ser_in;
  logic [3:0] dsize_m1;
  logic [15:0] host_wdata, host_rdata;
  logic ser_out, tx_full, rx_empty, rx_overrun, busy;

  ssi_fifo_path dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .dsize_m1(dsize_m1), .cmd_mode(cmd_mode),
    .bit_tick(bit_tick), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .ser_in(ser_in),
    .ser_out(ser_out), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_overrun(rx_overrun), .busy(busy)
  );

  int checks = 0, fails = 0;
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  bit ovf_exp = 1'b0;

  function automatic logic [15:0] msk(int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic wr(logic [15:0] d);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (txq.size() < 8) txq.push_back(d);
  endtask

  task automatic rd();
    logic [15:0] e;
    e = (rxq.size() != 0) ? rxq[0] : 16'h0;
    chk((rxq.size() != 0) ? "R5 R10 read data" : "R6 empty read", 32'(host_rdata), 32'(e));
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    if (rxq.size() != 0) void'(rxq.pop_front());
  endtask

  task automatic pulse(logic si);
    ser_in = si; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic frame(logic uw, int n);
    logic [15:0] word, rx;
    int txb, len, mism;
    word = txq.pop_front();
    txb = uw ? 8 : n;
    len = uw ? n + 8 : n;
    mism = 0; rx = 16'h0;
    cmd_mode = uw; dsize_m1 = 4'(n - 1);
    pulse(1'b0);
    chk("R9 busy in frame", 32'(busy), 32'd1);
    for (int k = 0; k < len; k++) begin
      logic expb, r;
      expb = (k < txb) ? word[txb - 1 - k] : 1'b0;
      if (ser_out !== expb) mism++;
      r = 1'($urandom % 2);
      rx = {rx[14:0], r};
      pulse(r);
    end
    chk(uw ? "R4 command stream" : "R3 data stream", 32'(mism), 32'd0);
    if (rxq.size() < 8) rxq.push_back(rx & msk(n));
    else ovf_exp = 1'b1;
    chk("R7 overrun flag", 32'(rx_overrun), 32'(ovf_exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b0; cmd_mode = 1'b0; bit_tick = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; ser_in = 1'b0;
    dsize_m1 = 4'd7; host_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_full", 32'(tx_full), 32'd0);
    chk("R1 rx_empty", 32'(rx_empty), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 ser_out", 32'(ser_out), 32'd0);
    chk("R1 overrun", 32'(rx_overrun), 32'd0);

    rd(); rd();
    chk("R6 still empty", 32'(rx_empty), 32'd1);

    for (int i = 0; i < 9; i++) wr(16'($urandom));
    chk("R2 tx_full", 32'(tx_full), 32'd1);
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    chk("R8 queue kept", 32'(tx_full), 32'd1);
    chk("R8 no frame rx", 32'(rx_empty), 32'd1);
    chk("R8 line idle", 32'(ser_out), 32'd0);
    chk("R9 busy pending", 32'(busy), 32'd1);

    en = 1'b1;
    frame(1'b0, 4);  frame(1'b0, 16); frame(1'b1, 4);  frame(1'b1, 16);
    frame(1'b0, 8);  frame(1'b1, 8);  frame(1'b0, 13); frame(1'b0, 5);
    chk("R9 idle", 32'(busy), 32'd0);
    chk("R2 not full", 32'(tx_full), 32'd0);

    wr(16'hA5C3); wr(16'h3C5A);
    frame(1'b0, 12);
    frame(1'b1, 6);
    for (int i = 0; i < 8; i++) rd();
    chk("R10 drained", 32'(rx_empty), 32'd1);
    chk("R7 sticky", 32'(rx_overrun), 32'd1);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) wr(16'($urandom));
      else if (op == 1) rd();
      else if (txq.size() != 0) frame(1'($urandom % 2), 4 + int'($urandom % 13));
    end
    chk("R2 full flag model", 32'(tx_full), 32'(txq.size() == 8));
    chk("R6 empty flag model", 32'(rx_empty), 32'(rxq.size() == 0));

    summary();
    $finish;
  end
endmodule